// File: doc/BRIEF.md
# Memory-Mapped Character FIFO Port

This block is a bus slave that moves 8-bit characters between a processor and a host-side byte stream. A processor store to the data register queues one character in a transmit FIFO. The transmit FIFO drains to the host through a valid/ready byte output. Bytes that arrive from the host through a valid/ready byte input collect in a receive FIFO. A processor load of the data register takes one of them out.

Each load of the data register returns more than the character. It also carries a flag that says whether a character was really taken, and the number of characters still waiting. Software can therefore poll without a second access. The control register holds two interrupt enables and shows the two pending conditions and the free space in the transmit FIFO. The receive-side condition and the transmit-side condition are set by programmable FIFO thresholds. The single active-high interrupt line is the OR of each pending condition gated by its own enable.

Top module: `mmio_char_port`

## Requirements
- R1: After reset the interrupt line is low, `host_tx_valid` is low, `host_rx_ready` is high, both enables are 0 and a control read returns 0x0040_0200 with the default depth of 64 and default thresholds of 8.
- R2: A write to address 0 (data) queues `bus_wdata[7:0]`; bits [31:8] are ignored. Queued characters appear on `host_tx_data` in the order written, and `host_tx_valid` is high exactly while the transmit FIFO is non-empty.
- R3: A data write while the transmit FIFO holds DEPTH characters is dropped and the queued characters are unchanged.
- R4: `host_rx_ready` is low exactly while the receive FIFO holds DEPTH characters. A host byte offered while it is low is discarded.
- R5: A data read with the receive FIFO non-empty removes the oldest character. In the cycle after the read, `bus_rdata` holds that character in bits [7:0], 1 in bit 15 and, in bits [31:16], the count before the read minus one.
- R6: A data read with the receive FIFO empty returns 0 in bits [15:0] and 0 in bits [31:16], and changes no FIFO state.
- R7: A control read (address 1) returns the read-interrupt enable in bit 0, the write-interrupt enable in bit 1, the read-pending flag in bit 8, the write-pending flag in bit 9 and the transmit FIFO free space in bits [31:16]. All other bits are 0.
- R8: Read-pending is 1 exactly when the receive FIFO has RD_THRESH or fewer free entries.
- R9: Write-pending is 1 exactly when the transmit FIFO holds WR_THRESH or fewer characters.
- R10: `irq` equals (read-pending AND bit 0) OR (write-pending AND bit 1).
- R11: A control write loads bit 0 and bit 1 from `bus_wdata[0]` and `bus_wdata[1]`, ignores the other bits and leaves both FIFOs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_read | input | 1 | Read strobe, one cycle per access |
| bus_write | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| host_rx_data | input | 8 | Byte from the host |
| host_rx_valid | input | 1 | Host byte present |
| host_rx_ready | output | 1 | Receive FIFO can accept a byte |
| host_tx_data | output | 8 | Byte to the host |
| host_tx_valid | output | 1 | Transmit FIFO has a byte |
| host_tx_ready | input | 1 | Host takes the byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checker watches the relations that hold in every cycle. These are the link between the FIFO fill levels and `host_tx_valid` and `host_rx_ready`, the interrupt equation against the thresholds, the bounds on the counts, the valid flag and the remaining count one cycle after a data read, and the retention of a full transmit FIFO under a dropped write. Some behaviour can only be shown by the bench's scenarios, because the checker does not follow the data path byte by byte. These are the order in which characters come out of each FIFO, the loss of the exact bytes offered to a full FIFO, the exact threshold boundaries as the FIFOs fill and drain, and the masking of the unused write bits.

// File: rtl/char_port_pkg.sv
`timescale 1ns/1ps
package char_port_pkg;
    // register select values
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // bit positions that software decodes
    localparam int B_RD_EN   = 0;
    localparam int B_WR_EN   = 1;
    localparam int B_RD_PEND = 8;
    localparam int B_WR_PEND = 9;
    localparam int B_VALID   = 15;
    localparam int B_LEVEL   = 16;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } irq_enables_t;

    typedef struct packed {
        irq_enables_t en;
        logic [31:0]  rdata;
    } port_state_t;
endpackage

// File: rtl/char_byte_fifo.sv
`timescale 1ns/1ps
module char_byte_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head_data,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [7:0]  mem [DEPTH];
    logic        push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.count != CW'(DEPTH));
        pop_ok  = pop && (st_q.count != '0);
        if (push_ok) st_d.wr_ptr = step(st_q.wr_ptr);
        if (pop_ok)  st_d.rd_ptr = step(st_q.rd_ptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= push_data;
    end

    assign head_data = mem[st_q.rd_ptr];
    assign level     = st_q.count;
    assign full      = (st_q.count == CW'(DEPTH));
    assign empty     = (st_q.count == '0);
endmodule

// File: rtl/char_irq_gen.sv
`timescale 1ns/1ps
module char_irq_gen #(
    parameter int DEPTH     = 64,
    parameter int RD_THRESH = 8,
    parameter int WR_THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] tx_level,
    input  logic          rd_en,
    input  logic          wr_en,
    output logic          rd_pend,
    output logic          wr_pend,
    output logic          irq
);
    logic [CW-1:0] rx_space;

    always_comb begin
        rx_space = CW'(DEPTH) - rx_level;
        rd_pend  = (rx_space <= CW'(RD_THRESH));
        wr_pend  = (tx_level <= CW'(WR_THRESH));
        irq      = (rd_pend && rd_en) || (wr_pend && wr_en);
    end
endmodule

// File: rtl/mmio_char_port.sv
`timescale 1ns/1ps
module mmio_char_port
    import char_port_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int RD_THRESH = 8,
    parameter int WR_THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_read,
    input  logic        bus_write,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  host_rx_data,
    input  logic        host_rx_valid,
    output logic        host_rx_ready,
    output logic [7:0]  host_tx_data,
    output logic        host_tx_valid,
    input  logic        host_tx_ready,
    output logic        irq
);
    port_state_t   st_d, st_q;

    logic [CW-1:0] rx_level, tx_level;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0]    rx_head;
    logic          tx_push, tx_pop, rx_push, rx_pop;
    logic          rd_pend, wr_pend;
    logic          rd_irq_en, wr_irq_en;
    logic [15:0]   rx_left, tx_space;
    logic          unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[31:8];

    assign tx_push = bus_write && (bus_addr == SEL_DATA);
    assign tx_pop  = host_tx_valid && host_tx_ready;
    assign rx_push = host_rx_valid && host_rx_ready;
    assign rx_pop  = bus_read && (bus_addr == SEL_DATA) && !rx_empty;

    char_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (bus_wdata[7:0]),
        .pop       (tx_pop),
        .head_data (host_tx_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    char_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (host_rx_data),
        .pop       (rx_pop),
        .head_data (rx_head),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    char_irq_gen #(
        .DEPTH     (DEPTH),
        .RD_THRESH (RD_THRESH),
        .WR_THRESH (WR_THRESH)
    ) u_irq (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rd_en    (rd_irq_en),
        .wr_en    (wr_irq_en),
        .rd_pend  (rd_pend),
        .wr_pend  (wr_pend),
        .irq      (irq)
    );

    assign host_tx_valid = !tx_empty;
    assign host_rx_ready = !rx_full;
    assign rd_irq_en     = st_q.en.rd_en;
    assign wr_irq_en     = st_q.en.wr_en;

    always_comb begin
        st_d     = st_q;
        rx_left  = 16'(rx_level) - (rx_pop ? 16'd1 : 16'd0);
        tx_space = 16'(DEPTH) - 16'(tx_level);

        if (bus_write && (bus_addr == SEL_CTRL)) begin
            st_d.en.rd_en = bus_wdata[B_RD_EN];
            st_d.en.wr_en = bus_wdata[B_WR_EN];
        end

        if (bus_read) begin
            st_d.rdata = '0;
            if (bus_addr == SEL_DATA) begin
                if (rx_pop) begin
                    st_d.rdata[7:0]     = rx_head;
                    st_d.rdata[B_VALID] = 1'b1;
                    st_d.rdata[31:B_LEVEL] = rx_left;
                end
            end else begin
                st_d.rdata[B_RD_EN]    = st_q.en.rd_en;
                st_d.rdata[B_WR_EN]    = st_q.en.wr_en;
                st_d.rdata[B_RD_PEND]  = rd_pend;
                st_d.rdata[B_WR_PEND]  = wr_pend;
                st_d.rdata[31:B_LEVEL] = tx_space;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/mmio_char_port_chk.sv
`timescale 1ns/1ps
module mmio_char_port_chk #(
    parameter int DEPTH     = 64,
    parameter int RD_THRESH = 8,
    parameter int WR_THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_addr,
    input logic          bus_read,
    input logic          bus_write,
    input logic [31:0]   bus_rdata,
    input logic          host_rx_ready,
    input logic          host_tx_valid,
    input logic          host_tx_ready,
    input logic          irq,
    input logic [CW-1:0] rx_level,
    input logic [CW-1:0] tx_level,
    input logic          rd_irq_en,
    input logic          wr_irq_en
);
    assert_tx_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_tx_valid == (tx_level != '0));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == CW'(DEPTH) && bus_write && !bus_addr && !host_tx_ready)
        |=> tx_level == CW'(DEPTH));

    assert_rx_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rx_ready == (rx_level != CW'(DEPTH)));

    assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_addr && rx_level != '0)
        |=> bus_rdata[15] && (bus_rdata[31:16] == 16'($past(rx_level)) - 16'd1));

    assert_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_addr && rx_level == '0)
        |=> (bus_rdata == 32'h0) && (rx_level <= CW'(1)));

    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((rd_irq_en && (CW'(DEPTH) - rx_level <= CW'(RD_THRESH)))
             || (wr_irq_en && (tx_level <= CW'(WR_THRESH)))));
endmodule

bind mmio_char_port mmio_char_port_chk #(
    .DEPTH     (DEPTH),
    .RD_THRESH (RD_THRESH),
    .WR_THRESH (WR_THRESH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_read      (bus_read),
    .bus_write     (bus_write),
    .bus_rdata     (bus_rdata),
    .host_rx_ready (host_rx_ready),
    .host_tx_valid (host_tx_valid),
    .host_tx_ready (host_tx_ready),
    .irq           (irq),
    .rx_level      (rx_level),
    .tx_level      (tx_level),
    .rd_irq_en     (rd_irq_en),
    .wr_irq_en     (wr_irq_en)
);

// File: tb/mmio_char_port_test.sv
`timescale 1ns/1ps
module mmio_char_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_read = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  host_rx_data = '0;
    logic        host_rx_valid = 1'b0;
    logic        host_rx_ready;
    logic [7:0]  host_tx_data;
    logic        host_tx_valid;
    logic        host_tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mmio_char_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_rx_data(host_rx_data), .host_rx_valid(host_rx_valid),
        .host_rx_ready(host_rx_ready), .host_tx_data(host_tx_data),
        .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready), .irq(irq)
    );

    // entry: {is_write, addr, wdata, expected read}
    localparam logic [65:0] VEC [0:7] = '{
        {1'b0, 1'b1, 32'h0,          32'h0040_0200},
        {1'b1, 1'b1, 32'hFFFF_FF03,  32'h0},
        {1'b0, 1'b1, 32'h0,          32'h0040_0203},
        {1'b1, 1'b0, 32'h0000_0041,  32'h0},
        {1'b1, 1'b0, 32'hFFFF_FF42,  32'h0},
        {1'b0, 1'b1, 32'h0,          32'h003E_0203},
        {1'b0, 1'b0, 32'h0,          32'h0000_0000},
        {1'b0, 1'b1, 32'h0,          32'h003E_0203}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_write = 1'b1;
        @(negedge clk);
        bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_read = 1'b1;
        @(negedge clk);
        bus_read = 1'b0;
        d = bus_rdata;
    endtask

    task automatic host_send(input logic [7:0] b);
        @(negedge clk);
        host_rx_data = b; host_rx_valid = 1'b1;
        @(negedge clk);
        host_rx_valid = 1'b0;
    endtask

    task automatic host_take(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk(tag, {31'd0, host_tx_valid}, 32'd1);
        chk(tag, {24'd0, host_tx_data}, {24'd0, exp});
        host_tx_ready = 1'b1;
        @(negedge clk);
        host_tx_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_valid", {31'd0, host_tx_valid}, 32'd0);
        chk("R1 rx_ready", {31'd0, host_rx_ready}, 32'd1);

        // table walk: R7 R11 R2 R6
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][65]) bus_wr(VEC[i][64], VEC[i][63:32]);
            else begin
                bus_rd(VEC[i][64], rd);
                chk($sformatf("R7/R6/R11 table step %0d", i), rd, VEC[i][31:0]);
            end
        end
        chk("R10 irq write pending enabled", {31'd0, irq}, 32'd1);

        // R11 control write leaves FIFOs alone
        bus_wr(1'b1, 32'h0);
        bus_rd(1'b1, rd);
        chk("R11 ctrl clear", rd, 32'h003E_0200);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);

        // R2 order and masking of upper bits
        host_take("R2 first char", 8'h41);
        host_take("R2 second char", 8'h42);
        @(negedge clk);
        chk("R2 tx empty", {31'd0, host_tx_valid}, 32'd0);

        // R5 receive path
        host_send(8'h10); host_send(8'h11); host_send(8'h12);
        bus_rd(1'b0, rd); chk("R5 read 1", rd, 32'h0002_8010);
        bus_rd(1'b0, rd); chk("R5 read 2", rd, 32'h0001_8011);
        for (int i = 0; i < 63; i++) host_send(8'h20 + 8'(i));
        chk("R4 rx full ready low", {31'd0, host_rx_ready}, 32'd0);
        host_send(8'hEE);
        bus_rd(1'b1, rd);
        chk("R8 rx pending at full", rd, 32'h0040_0300);
        bus_wr(1'b1, 32'h1);
        chk("R10 read irq", {31'd0, irq}, 32'd1);
        bus_rd(1'b0, rd); chk("R5 read oldest", rd, 32'h003F_8012);
        for (int j = 0; j < 63; j++) begin
            bus_rd(1'b0, rd);
            chk($sformatf("R5 drain %0d", j), rd,
                (32'(62 - j) << 16) | 32'h8000 | 32'(8'h20 + 8'(j)));
            chk($sformatf("R8 threshold at level %0d", 62 - j), {31'd0, irq},
                {31'd0, (62 - j) >= 56});
        end
        bus_rd(1'b0, rd);
        chk("R4/R6 dropped byte absent, empty read", rd, 32'h0);

        // R3 and R9 transmit overflow and threshold
        bus_wr(1'b1, 32'h3);
        chk("R9 tx empty pending", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 66; i++) bus_wr(1'b0, 32'(8'h80 + 8'(i)));
        bus_rd(1'b1, rd);
        chk("R3/R7 tx full ctrl", rd, 32'h0000_0003);
        chk("R9 no pending when full", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 64; i++) begin
            host_take($sformatf("R3 drain %0d", i), 8'h80 + 8'(i));
            chk($sformatf("R9 threshold at level %0d", 63 - i), {31'd0, irq},
                {31'd0, (63 - i) <= 8});
        end
        @(negedge clk);
        chk("R3 extra writes dropped", {31'd0, host_tx_valid}, 32'd0);
        finish_run();
    end
endmodule